// File: doc/BRIEF.md
# Per-Stage Ambient Baseline Tracker with Proximity Detection

This block follows the resting ("ambient") level of each of twelve conversion stages of a capacitive sensing front end. Conversion results arrive one at a time. Each one is tagged with the index of the stage it belongs to. A one-cycle strobe marks the end of each full conversion sequence. A power-mode input chooses whether the full-power or the low-power timing fields apply at each sequence boundary.

For every stage the block keeps a slow-filtered baseline, and it raises a proximity bit when a result strays far from that baseline. While that bit is set, baseline tracking is frozen, so a hand resting on the sensor is not learned into the baseline. A stage can stay above its baseline for too many sequences in a row, for example after a real environmental shift. When that happens the block reloads the baseline with the stage's latest result and drops the proximity bit.

Control fields are loaded through a small register-style write port. A combinational read port returns the baseline of any stage.

Top module: `prox_ambient_tracker`

## Requirements
- R1: After reset, the first result for a stage whose calibration-enable bit is set copies that result into the stage's baseline exactly and does not raise proximity. A stage that has not been seeded never raises proximity.
- R2: On a seeded stage, take a result whose absolute distance d from the baseline is not above the detection level and whose |d| is greater than the update level (word 3 bits [15:8]). Then, with proximity clear, the baseline becomes baseline + ((result − baseline) >>> 4), using an arithmetic shift and limited to 0..65535. When |d| is at or below the update level, the baseline does not change.
- R3: On a seeded stage, a result with |d| greater than the detection level (word 1 bits [13:8] times 16) sets bit s of `prox_status`, where s is the stage index, at the clock edge that takes that result.
- R4: While a stage's proximity bit is set, its results never change its baseline.
- R5: When calibration-enable bit s (word 0 bits [11:0]) is clear, stage s's baseline never changes: it is not seeded, not filtered and not reloaded.
- R6: A set proximity bit clears at the sequence strobe that completes N consecutive sequences without a far result for that stage. A far result restarts the run. N is word 1 bits [3:0] in full power (`low_power`=0) and word 1 bits [7:4] in low power. N=0 acts as 1.
- R7: Count the consecutive sequences in which some result for a stage exceeded its baseline by more than the recalibration level (word 3 bits [7:0]; upward only). At the strobe that brings this count to T, the baseline is reloaded with the stage's last result, proximity clears and the count restarts. T is word 2 bits [7:0] in full power and word 2 bits [13:8] in low power. T=0 disables the reload. A sequence without such a result resets the count.
- R8: `prox_status` and all baselines change only at an edge that takes a result for a stage index below 12, or at an edge that takes a sequence strobe. Results with stage index 12 to 15 are ignored.
- R9: After reset, `prox_status` is zero and every baseline reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | 2 | Control word select (0 enables, 1 counts/detect, 2 recal times, 3 levels) |
| cfg_wdata | input | 16 | Control word data |
| low_power | input | 1 | 1 selects the low-power count and time fields |
| res_valid | input | 1 | A conversion result is present |
| res_stage | input | 4 | Stage index of the result |
| res_data | input | 16 | Conversion result |
| seq_end | input | 1 | End-of-sequence strobe, never in the same cycle as `res_valid` |
| amb_rd_stage | input | 4 | Stage whose baseline is read |
| prox_status | output | 12 | Proximity bit per stage |
| amb_rd_data | output | 16 | Baseline of the selected stage (0 for indices 12 to 15) |

## Verification
Every stage is seeded. Each enabled stage then gets a fixed set of small signed offsets that fall on both sides of the update level and just under the detection level. This separates "no update", "filtered step" (including rounding of negative steps through the arithmetic shift) and "detect". Proximity runs are driven in both power modes, with a far result in the middle of a quiet run, to tell the full-power count from the low-power count and to show the run restart. Upward-offset runs that are broken by one quiet sequence, followed by uninterrupted runs, tell the reload timeout in each mode apart from a plain counter. Results for a disabled stage and for indices 12 to 15, and zero-valued count and time fields, cover the ignore and boundary paths.

// File: rtl/prox_pkg.sv
package prox_pkg;
  localparam int N_STAGES   = 12;
  localparam int DW         = 16;
  localparam int STG_W      = 4;
  localparam int CNT_W      = 4;
  localparam int RTIM_W     = 8;
  localparam int LPRT_W     = 6;
  localparam int DET_W      = 6;
  localparam int DET_SHIFT  = 4;
  localparam int LVL_W      = 8;
  localparam int FILT_SHIFT = 4;
  localparam int DETL_W     = DET_W + DET_SHIFT;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt_lim;
    logic [RTIM_W-1:0] recal_lim;
    logic [DETL_W-1:0] det_lvl;
    logic [LVL_W-1:0]  recal_lvl;
    logic [LVL_W-1:0]  upd_lvl;
  } stage_cfg_t;
endpackage

// File: rtl/prox_cfg_regs.sv
module prox_cfg_regs
  import prox_pkg::*;
#(
  parameter int NUM_STAGES = N_STAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [15:0]           wdata_i,
  input  logic                  low_power_i,
  output logic [NUM_STAGES-1:0] cal_en_o,
  output stage_cfg_t            cfg_o
);
  logic [NUM_STAGES-1:0] cal_en_q, cal_en_n;
  logic [CNT_W-1:0]      fp_cnt_q, fp_cnt_n, lp_cnt_q, lp_cnt_n;
  logic [DET_W-1:0]      det_q, det_n;
  logic [RTIM_W-1:0]     fp_rt_q, fp_rt_n;
  logic [LPRT_W-1:0]     lp_rt_q, lp_rt_n;
  logic [LVL_W-1:0]      rlvl_q, rlvl_n, ulvl_q, ulvl_n;
  logic                  unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata_i[15:14]};

  always_comb begin
    cal_en_n = cal_en_q;
    fp_cnt_n = fp_cnt_q;
    lp_cnt_n = lp_cnt_q;
    det_n    = det_q;
    fp_rt_n  = fp_rt_q;
    lp_rt_n  = lp_rt_q;
    rlvl_n   = rlvl_q;
    ulvl_n   = ulvl_q;
    if (we_i) begin
      unique case (addr_i)
        2'd0: cal_en_n = wdata_i[NUM_STAGES-1:0];
        2'd1: begin
          fp_cnt_n = wdata_i[CNT_W-1:0];
          lp_cnt_n = wdata_i[2*CNT_W-1:CNT_W];
          det_n    = wdata_i[2*CNT_W+DET_W-1:2*CNT_W];
        end
        2'd2: begin
          fp_rt_n = wdata_i[RTIM_W-1:0];
          lp_rt_n = wdata_i[RTIM_W+LPRT_W-1:RTIM_W];
        end
        default: begin
          rlvl_n = wdata_i[LVL_W-1:0];
          ulvl_n = wdata_i[2*LVL_W-1:LVL_W];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_en_q <= '0;
      fp_cnt_q <= '0;
      lp_cnt_q <= '0;
      det_q    <= '0;
      fp_rt_q  <= '0;
      lp_rt_q  <= '0;
      rlvl_q   <= '0;
      ulvl_q   <= '0;
    end else if (we_i) begin
      cal_en_q <= cal_en_n;
      fp_cnt_q <= fp_cnt_n;
      lp_cnt_q <= lp_cnt_n;
      det_q    <= det_n;
      fp_rt_q  <= fp_rt_n;
      lp_rt_q  <= lp_rt_n;
      rlvl_q   <= rlvl_n;
      ulvl_q   <= ulvl_n;
    end
  end

  always_comb begin
    cal_en_o          = cal_en_q;
    cfg_o.cnt_lim     = low_power_i ? lp_cnt_q : fp_cnt_q;
    cfg_o.recal_lim   = low_power_i ? RTIM_W'(lp_rt_q) : fp_rt_q;
    cfg_o.det_lvl     = {det_q, {DET_SHIFT{1'b0}}};
    cfg_o.recal_lvl   = rlvl_q;
    cfg_o.upd_lvl     = ulvl_q;
  end
endmodule

// File: rtl/prox_stage_tracker.sv
module prox_stage_tracker
  import prox_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [DW-1:0] data_i,
  input  logic          tick_i,
  input  logic          cal_en_i,
  input  stage_cfg_t    cfg_i,
  output logic [DW-1:0] amb_o,
  output logic          prox_o
);
  localparam int XW = DW + 2;

  logic [DW-1:0]     amb_q, amb_n, last_q, last_n;
  logic              seeded_q, seeded_n, prox_q, prox_n;
  logic              far_seen_q, far_seen_n, high_seen_q, high_seen_n;
  logic [CNT_W-1:0]  quiet_q, quiet_n;
  logic [RTIM_W-1:0] rt_q, rt_n;

  logic signed [XW-1:0] diff, step, sum;
  logic [XW-1:0]        absd;
  logic [DW-1:0]        filt;
  logic                 far, high, upd;
  logic [CNT_W-1:0]     lim_eff;
  logic [CNT_W:0]       quiet_inc;
  logic [RTIM_W:0]      rt_inc;

  always_comb begin
    diff = $signed({2'b00, data_i}) - $signed({2'b00, amb_q});
    absd = diff[XW-1] ? $unsigned(-diff) : $unsigned(diff);
    step = diff >>> FILT_SHIFT;
    sum  = $signed({2'b00, amb_q}) + step;
    if (sum[XW-1])      filt = '0;
    else if (sum[DW])   filt = '1;
    else                filt = sum[DW-1:0];
    far  = absd > XW'(cfg_i.det_lvl);
    high = !diff[XW-1] && (absd > XW'(cfg_i.recal_lvl));
    upd  = absd > XW'(cfg_i.upd_lvl);
    lim_eff   = (cfg_i.cnt_lim == '0) ? CNT_W'(1) : cfg_i.cnt_lim;
    quiet_inc = {1'b0, quiet_q} + 1'b1;
    rt_inc    = {1'b0, rt_q} + 1'b1;
  end

  always_comb begin
    amb_n       = amb_q;
    last_n      = last_q;
    seeded_n    = seeded_q;
    prox_n      = prox_q;
    far_seen_n  = far_seen_q;
    high_seen_n = high_seen_q;
    quiet_n     = quiet_q;
    rt_n        = rt_q;
    if (hit_i) begin
      last_n = data_i;
      if (!seeded_q) begin
        if (cal_en_i) begin
          amb_n    = data_i;
          seeded_n = 1'b1;
        end
      end else begin
        if (far) begin
          prox_n     = 1'b1;
          quiet_n    = '0;
          far_seen_n = 1'b1;
        end
        if (high) high_seen_n = 1'b1;
        if (cal_en_i && !prox_n && upd) amb_n = filt;
      end
    end else if (tick_i) begin
      if (prox_q) begin
        if (far_seen_q) begin
          quiet_n = '0;
        end else if (quiet_inc >= {1'b0, lim_eff}) begin
          prox_n  = 1'b0;
          quiet_n = '0;
        end else begin
          quiet_n = quiet_inc[CNT_W-1:0];
        end
      end
      if (high_seen_q && cal_en_i && (cfg_i.recal_lim != '0)) begin
        if (rt_inc >= {1'b0, cfg_i.recal_lim}) begin
          amb_n   = last_q;
          prox_n  = 1'b0;
          quiet_n = '0;
          rt_n    = '0;
        end else begin
          rt_n = rt_inc[RTIM_W-1:0];
        end
      end else begin
        rt_n = '0;
      end
      far_seen_n  = 1'b0;
      high_seen_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amb_q       <= '0;
      last_q      <= '0;
      seeded_q    <= 1'b0;
      prox_q      <= 1'b0;
      far_seen_q  <= 1'b0;
      high_seen_q <= 1'b0;
      quiet_q     <= '0;
      rt_q        <= '0;
    end else if (hit_i || tick_i) begin
      amb_q       <= amb_n;
      last_q      <= last_n;
      seeded_q    <= seeded_n;
      prox_q      <= prox_n;
      far_seen_q  <= far_seen_n;
      high_seen_q <= high_seen_n;
      quiet_q     <= quiet_n;
      rt_q        <= rt_n;
    end
  end

  assign amb_o  = amb_q;
  assign prox_o = prox_q;

  assert_seed_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && !seeded_q && cal_en_i |=> (amb_q == $past(data_i)) && !prox_q);

  assert_unseeded_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seeded_q |-> !prox_q);

  assert_far_sets_prox_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && seeded_q && far |=> prox_q);

  assert_frozen_in_prox_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prox_q && !tick_i |=> $stable(amb_q));

  assert_disabled_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en_i |=> $stable(amb_q));

  assert_clear_at_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prox_q) |-> $past(tick_i));

  assert_timer_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !high_seen_q |=> rt_q == '0);
endmodule

// File: rtl/prox_amb_readout.sv
module prox_amb_readout
  import prox_pkg::*;
#(
  parameter int NUM_STAGES = N_STAGES
) (
  input  logic [NUM_STAGES*DW-1:0] amb_flat_i,
  input  logic [STG_W-1:0]         sel_i,
  output logic [DW-1:0]            data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (sel_i == STG_W'(k)) data_o = amb_flat_i[k*DW +: DW];
    end
  end
endmodule

// File: rtl/prox_ambient_tracker.sv
module prox_ambient_tracker
  import prox_pkg::*;
#(
  parameter int NUM_STAGES = N_STAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_addr,
  input  logic [15:0]           cfg_wdata,
  input  logic                  low_power,
  input  logic                  res_valid,
  input  logic [STG_W-1:0]      res_stage,
  input  logic [DW-1:0]         res_data,
  input  logic                  seq_end,
  input  logic [STG_W-1:0]      amb_rd_stage,
  output logic [NUM_STAGES-1:0] prox_status,
  output logic [DW-1:0]         amb_rd_data
);
  logic [NUM_STAGES-1:0]    cal_en;
  stage_cfg_t               cfg;
  logic [NUM_STAGES*DW-1:0] amb_flat;

  prox_cfg_regs #(.NUM_STAGES(NUM_STAGES)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we),
    .addr_i     (cfg_addr),
    .wdata_i    (cfg_wdata),
    .low_power_i(low_power),
    .cal_en_o   (cal_en),
    .cfg_o      (cfg)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic hit;
    assign hit = res_valid && (res_stage == STG_W'(g));
    prox_stage_tracker trk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit),
      .data_i  (res_data),
      .tick_i  (seq_end),
      .cal_en_i(cal_en[g]),
      .cfg_i   (cfg),
      .amb_o   (amb_flat[g*DW +: DW]),
      .prox_o  (prox_status[g])
    );
  end

  prox_amb_readout #(.NUM_STAGES(NUM_STAGES)) rd_i (
    .amb_flat_i(amb_flat),
    .sel_i     (amb_rd_stage),
    .data_o    (amb_rd_data)
  );

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid && !seq_end |=> $stable(prox_status) && $stable(amb_flat));

  assert_bad_index_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_stage >= STG_W'(NUM_STAGES)) && !seq_end
      |=> $stable(prox_status) && $stable(amb_flat));
endmodule

// File: tb/prox_ambient_tracker_tb.sv
module prox_ambient_tracker_tb_top;
  localparam int NS = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        low_power = 1'b0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_stage = '0;
  logic [15:0] res_data = '0;
  logic        seq_end = 1'b0;
  logic [3:0]  amb_rd_stage = '0;
  logic [11:0] prox_status;
  logic [15:0] amb_rd_data;

  prox_ambient_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .low_power(low_power), .res_valid(res_valid),
    .res_stage(res_stage), .res_data(res_data), .seq_end(seq_end),
    .amb_rd_stage(amb_rd_stage), .prox_status(prox_status),
    .amb_rd_data(amb_rd_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected-state mirror built from the requirements
  int amb_m[NS], last_m[NS], quiet_m[NS], rt_m[NS];
  bit seeded_m[NS], prox_m[NS], far_m[NS], high_m[NS];
  int cal_m, fpc_m, lpc_m, det_m, fpr_m, lpr_m, rlvl_m, ulvl_m;

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic check_all(input string req);
    int pm = 0;
    for (int s = 0; s < NS; s++) begin
      amb_rd_stage = 4'(s);
      #1;
      chk(req, int'(amb_rd_data), amb_m[s], $sformatf("baseline stage %0d", s));
      if (prox_m[s]) pm |= (1 << s);
    end
    for (int s = NS; s < 16; s++) begin
      amb_rd_stage = 4'(s);
      #0.2;
      chk(req, int'(amb_rd_data), 0, $sformatf("readout index %0d", s));
    end
    chk(req, int'(prox_status), pm, "prox_status");
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: cal_m = d & 12'hFFF;
      1: begin fpc_m = d & 15; lpc_m = (d >> 4) & 15; det_m = ((d >> 8) & 63) * 16; end
      2: begin fpr_m = d & 255; lpr_m = (d >> 8) & 63; end
      default: begin rlvl_m = d & 255; ulvl_m = (d >> 8) & 255; end
    endcase
  endtask

  task automatic send(input int s, input int d);
    int diff, absd, nv;
    @(negedge clk);
    res_valid = 1'b1; res_stage = 4'(s); res_data = 16'(d);
    @(negedge clk);
    res_valid = 1'b0;
    if (s < NS) begin
      last_m[s] = d;
      if (!seeded_m[s]) begin
        if (cal_m[s]) begin amb_m[s] = d; seeded_m[s] = 1; end
      end else begin
        diff = d - amb_m[s];
        absd = diff < 0 ? -diff : diff;
        if (absd > det_m) begin prox_m[s] = 1; quiet_m[s] = 0; far_m[s] = 1; end
        if (diff > rlvl_m) high_m[s] = 1;
        if (cal_m[s] && !prox_m[s] && absd > ulvl_m) begin
          nv = amb_m[s] + (diff >>> 4);
          if (nv < 0) nv = 0;
          if (nv > 65535) nv = 65535;
          amb_m[s] = nv;
        end
      end
    end
  endtask

  task automatic tick();
    int lim, rlim;
    @(negedge clk);
    seq_end = 1'b1;
    @(negedge clk);
    seq_end = 1'b0;
    lim  = low_power ? lpc_m : fpc_m;
    if (lim == 0) lim = 1;
    rlim = low_power ? lpr_m : fpr_m;
    for (int s = 0; s < NS; s++) begin
      if (prox_m[s]) begin
        if (far_m[s]) quiet_m[s] = 0;
        else if (quiet_m[s] + 1 >= lim) begin prox_m[s] = 0; quiet_m[s] = 0; end
        else quiet_m[s]++;
      end
      if (high_m[s] && cal_m[s] && rlim != 0) begin
        if (rt_m[s] + 1 >= rlim) begin
          amb_m[s] = last_m[s]; prox_m[s] = 0; quiet_m[s] = 0; rt_m[s] = 0;
        end else rt_m[s]++;
      end else rt_m[s] = 0;
      far_m[s] = 0; high_m[s] = 0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int deltas[7] = '{5, 9, -9, 30, -63, 63, -20};
    int base5, base6, base7;
    for (int s = 0; s < NS; s++) begin
      amb_m[s] = 0; last_m[s] = 0; quiet_m[s] = 0; rt_m[s] = 0;
      seeded_m[s] = 0; prox_m[s] = 0; far_m[s] = 0; high_m[s] = 0;
    end
    cal_m = 0; fpc_m = 0; lpc_m = 0; det_m = 0; fpr_m = 0; lpr_m = 0; rlvl_m = 0; ulvl_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");

    cfg_write(0, 16'h07FF);   // stage 11 disabled
    cfg_write(1, 16'h0432);   // fp cnt 2, lp cnt 3, detect 4*16
    cfg_write(2, 16'h0203);   // fp recal 3, lp recal 2
    cfg_write(3, 16'h0828);   // recal level 40, update level 8

    // R1 seeding, R5 for stage 11
    for (int s = 0; s < NS; s++) begin
      send(s, 1000 + 100 * s);
      check_all(s == 11 ? "R5" : "R1");
    end

    // R2 slow filter sweep
    for (int s = 0; s < 11; s++)
      foreach (deltas[k]) begin
        send(s, amb_m[s] + deltas[k]);
        check_all("R2");
      end
    tick(); check_all("R7");
    tick(); check_all("R7");

    // R3 set, R4 freeze, R6 full-power clear
    send(3, amb_m[3] + 200); check_all("R3");
    send(3, amb_m[3] + 30);  check_all("R4");
    send(3, amb_m[3] - 40);  check_all("R4");
    tick(); check_all("R6");
    tick(); check_all("R6");

    // R6 low-power clear with restart
    low_power = 1'b1;
    send(4, amb_m[4] - 150); check_all("R3");
    tick(); check_all("R6");
    send(4, amb_m[4] - 150); check_all("R4");
    tick(); check_all("R6");
    tick(); check_all("R6");
    tick(); check_all("R6");

    // R7 low-power reload on stage 6
    base6 = amb_m[6];
    for (int k = 0; k < 2; k++) begin
      send(6, base6 + 100); tick(); check_all("R7");
    end
    low_power = 1'b0;

    // R7 full-power reload with a broken run on stage 7, straight run on 5
    base7 = amb_m[7];
    send(7, base7 + 50); tick(); check_all("R7");
    send(7, base7 + 50); tick(); check_all("R7");
    tick(); check_all("R7");
    base5 = amb_m[5];
    for (int k = 0; k < 3; k++) begin
      send(5, base5 + 100); send(7, base7 + 50); tick(); check_all("R7");
    end

    // R8 ignored indices and idle cycles
    send(12, 5000); check_all("R8");
    send(13, 100);  check_all("R8");
    send(15, 9999); check_all("R8");
    repeat (4) @(negedge clk);
    check_all("R8");

    // R5 disabled stage stays untouched
    send(11, 9000); tick(); check_all("R5");
    send(11, 20);   tick(); check_all("R5");

    // R6 count of zero acts as one
    cfg_write(1, 16'h0430);
    send(2, amb_m[2] + 300); check_all("R3");
    tick(); check_all("R6");

    // R7 time of zero disables reload
    cfg_write(2, 16'h0200);
    for (int k = 0; k < 4; k++) begin
      send(8, amb_m[8] + 60); tick(); check_all("R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule